// File: doc/BRIEF.md
# Base-Register Way Record Table

This block remembers, for each integer base register, the cache way and set that the last normal access through that register reached. It also keeps a signed bound that places the line relative to the register's value. It is read in the execute stage alongside address generation. A load or store presents its base register number and immediate offset. When the offset falls inside the 64-byte window that the bound describes, the block flags a direct access, so the cache can read one way without a tag compare or translation lookup. Otherwise the access goes through the normal path.

After a normal access the memory stage reports the way, the set and the byte position of the effective address within its line, and the entry is rebuilt. A rebuild in the same cycle as a lookup of that register is forwarded to the lookup, so back-to-back accesses through one register can use the new record at once. A register write that is not an add-immediate clears the record. An add-immediate instead shifts the bound by the immediate, so the record keeps pointing at the same line.

Top module: `way_record_table`

## Requirements
- R1: After reset every entry is invalid, acc_valid_o and direct_o are 0, and a lookup of any register reports a normal access.
- R2: A lookup presented in cycle N is reported in cycle N+1. acc_valid_o is 1, and direct_o is 1 exactly when the entry is valid and bound <= offset < bound + 64, where both offset and bound are signed.
- R3: A rebuild stores bound = offset - position, where position is the 6-bit byte index of the effective address in its line. It also stores way and set and marks the entry valid. Example: offset 4 at position 12 gives bound -8, so offsets -8 to 55 hit.
- R4: A register write that is not an add-immediate clears the entry's valid bit.
- R5: An add-immediate write subtracts the sign-extended 12-bit immediate from the bound and keeps the valid bit.
- R6: The bound is a 14-bit signed value. If an add-immediate would take it outside -8192..8191, the entry is invalidated instead of wrapping.
- R7: When a rebuild and a register write hit the same entry in the same cycle, the rebuild wins.
- R8: A rebuild and a lookup of the same register in the same cycle: the lookup uses the record being written.
- R9: A register write in the same cycle as a lookup of that register does not affect that lookup; it applies from the next cycle.
- R10: Events on one register leave every other entry unchanged.
- R11: When direct_o is 0, way_o and set_o are 0; on a direct access they carry the stored way and set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_reg_i | input | 4 | Base register of the lookup |
| lk_off_i | input | 12 | Signed immediate offset of the lookup |
| rb_valid_i | input | 1 | Rebuild after a normal access |
| rb_reg_i | input | 4 | Base register of the rebuilt entry |
| rb_off_i | input | 12 | Signed offset the normal access used |
| rb_pos_i | input | 6 | Byte position of the effective address within its line |
| rb_way_i | input | 2 | Way that the normal access hit |
| rb_set_i | input | 6 | Set that the normal access hit |
| wr_valid_i | input | 1 | Base register write |
| wr_reg_i | input | 4 | Register being written |
| wr_addi_i | input | 1 | Write is an add-immediate |
| wr_imm_i | input | 12 | Signed immediate of the add-immediate |
| acc_valid_o | output | 1 | A lookup was presented in the previous cycle |
| direct_o | output | 1 | That lookup may access the cache directly |
| way_o | output | 2 | Way for the direct access |
| set_o | output | 6 | Set for the direct access |

## Verification
The assertions check the following on every cycle:
- an entry that sees no event holds its contents;
- a plain register write clears the entry;
- a rebuild always leaves a valid entry with the computed bound;
- an add-immediate either shifts the bound exactly or invalidates the entry;
- the outputs stay gated to zero when no direct access is flagged.

Only the bench's scenarios can show the rest:
- that the window edges sit at bound and bound+63;
- that the rebuild is forwarded to a same-cycle lookup;
- that an out-of-range bound comes back invalid rather than wrapped after a series of add-immediates;
- that a same-cycle write stays hidden from the lookup.

// File: rtl/wrt_pkg.sv
package wrt_pkg;
  localparam int unsigned WRT_NUM_REGS   = 16;
  localparam int unsigned WRT_OFF_W      = 12;
  localparam int unsigned WRT_LINE_BYTES = 64;
  localparam int unsigned WRT_WAY_W      = 2;
  localparam int unsigned WRT_SET_W      = 6;
  localparam int unsigned WRT_BOUND_W    = 14;
endpackage

// File: rtl/wrt_bound_calc.sv
module wrt_bound_calc #(
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned POS_W   = 6,
  parameter int unsigned BOUND_W = 14
) (
  input  logic signed [OFF_W-1:0]   off_i,
  input  logic        [POS_W-1:0]   pos_i,
  output logic signed [BOUND_W-1:0] bound_o
);
  logic signed [BOUND_W-1:0] off_ext;
  logic signed [BOUND_W-1:0] pos_ext;

  always_comb begin
    off_ext = {{(BOUND_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    pos_ext = {{(BOUND_W-POS_W){1'b0}}, pos_i};
    bound_o = off_ext - pos_ext;
  end
endmodule

// File: rtl/wrt_range_check.sv
module wrt_range_check #(
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned BOUND_W    = 14,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                      valid_i,
  input  logic signed [BOUND_W-1:0] bound_i,
  input  logic signed [OFF_W-1:0]   off_i,
  output logic                      hit_o
);
  localparam int unsigned CW = BOUND_W + 2;

  logic signed [CW-1:0] lo, hi, off;

  always_comb begin
    lo    = {{2{bound_i[BOUND_W-1]}}, bound_i};
    hi    = lo + CW'(LINE_BYTES);
    off   = {{(CW-OFF_W){off_i[OFF_W-1]}}, off_i};
    hit_o = valid_i && (off >= lo) && (off < hi);
  end
endmodule

// File: rtl/wrt_entry.sv
module wrt_entry #(
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned BOUND_W = 14,
  parameter int unsigned PTR_W   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rb_sel_i,
  input  logic signed [BOUND_W-1:0] rb_bound_i,
  input  logic        [PTR_W-1:0]   rb_ptr_i,
  input  logic                      wr_sel_i,
  input  logic                      wr_addi_i,
  input  logic signed [OFF_W-1:0]   wr_imm_i,
  output logic                      valid_o,
  output logic signed [BOUND_W-1:0] bound_o,
  output logic        [PTR_W-1:0]   ptr_o
);
  localparam int unsigned XW = BOUND_W + 1;

  logic                      valid_q;
  logic signed [BOUND_W-1:0] bound_q;
  logic        [PTR_W-1:0]   ptr_q;
  logic signed [XW-1:0]      imm_ext, shifted;
  logic                      ovf;

  always_comb begin
    imm_ext = {{(XW-OFF_W){wr_imm_i[OFF_W-1]}}, wr_imm_i};
    shifted = {bound_q[BOUND_W-1], bound_q} - imm_ext;
    ovf     = shifted[XW-1] ^ shifted[XW-2];
  end

  // rebuild has priority over a register update (R7)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bound_q <= '0;
      ptr_q   <= '0;
    end else if (rb_sel_i) begin
      valid_q <= 1'b1;
      bound_q <= rb_bound_i;
      ptr_q   <= rb_ptr_i;
    end else if (wr_sel_i) begin
      if (!wr_addi_i || ovf) begin
        valid_q <= 1'b0;
      end else begin
        bound_q <= shifted[BOUND_W-1:0];
      end
    end
  end

  assign valid_o = valid_q;
  assign bound_o = bound_q;
  assign ptr_o   = ptr_q;

  assert_clear_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && !wr_addi_i && !rb_sel_i) |=> !valid_q);

  assert_rebuild_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_sel_i |=> (valid_q && bound_q == $past(rb_bound_i) && ptr_q == $past(rb_ptr_i)));

  assert_addi_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && wr_addi_i && !rb_sel_i) |=>
      (!valid_q || ({bound_q[BOUND_W-1], bound_q} ==
                    {$past(bound_q[BOUND_W-1]), $past(bound_q)} - $past(imm_ext))));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rb_sel_i && !wr_sel_i) |=> ($stable(valid_q) && $stable(bound_q) && $stable(ptr_q)));
endmodule

// File: rtl/way_record_table.sv
module way_record_table
  import wrt_pkg::*;
#(
  parameter int unsigned NUM_REGS   = WRT_NUM_REGS,
  parameter int unsigned OFF_W      = WRT_OFF_W,
  parameter int unsigned LINE_BYTES = WRT_LINE_BYTES,
  parameter int unsigned WAY_W      = WRT_WAY_W,
  parameter int unsigned SET_W      = WRT_SET_W,
  parameter int unsigned BOUND_W    = WRT_BOUND_W,
  localparam int unsigned REG_W     = $clog2(NUM_REGS),
  localparam int unsigned POS_W     = $clog2(LINE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lk_valid_i,
  input  logic [REG_W-1:0]        lk_reg_i,
  input  logic signed [OFF_W-1:0] lk_off_i,
  input  logic                    rb_valid_i,
  input  logic [REG_W-1:0]        rb_reg_i,
  input  logic signed [OFF_W-1:0] rb_off_i,
  input  logic [POS_W-1:0]        rb_pos_i,
  input  logic [WAY_W-1:0]        rb_way_i,
  input  logic [SET_W-1:0]        rb_set_i,
  input  logic                    wr_valid_i,
  input  logic [REG_W-1:0]        wr_reg_i,
  input  logic                    wr_addi_i,
  input  logic signed [OFF_W-1:0] wr_imm_i,
  output logic                    acc_valid_o,
  output logic                    direct_o,
  output logic [WAY_W-1:0]        way_o,
  output logic [SET_W-1:0]        set_o
);
  localparam int unsigned PTR_W = SET_W + WAY_W;

  logic signed [BOUND_W-1:0] rb_bound;
  logic [PTR_W-1:0]          rb_ptr;
  logic                      valid_a [NUM_REGS];
  logic signed [BOUND_W-1:0] bound_a [NUM_REGS];
  logic [PTR_W-1:0]          ptr_a   [NUM_REGS];

  assign rb_ptr = {rb_set_i, rb_way_i};

  wrt_bound_calc #(.OFF_W(OFF_W), .POS_W(POS_W), .BOUND_W(BOUND_W)) u_bound (
    .off_i(rb_off_i), .pos_i(rb_pos_i), .bound_o(rb_bound)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    wrt_entry #(.OFF_W(OFF_W), .BOUND_W(BOUND_W), .PTR_W(PTR_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rb_sel_i  (rb_valid_i && (rb_reg_i == REG_W'(g))),
      .rb_bound_i(rb_bound),
      .rb_ptr_i  (rb_ptr),
      .wr_sel_i  (wr_valid_i && (wr_reg_i == REG_W'(g))),
      .wr_addi_i (wr_addi_i),
      .wr_imm_i  (wr_imm_i),
      .valid_o   (valid_a[g]),
      .bound_o   (bound_a[g]),
      .ptr_o     (ptr_a[g])
    );
  end

  // forward a same-cycle rebuild to the lookup (R8)
  logic                      fwd;
  logic                      sel_valid;
  logic signed [BOUND_W-1:0] sel_bound;
  logic [PTR_W-1:0]          sel_ptr;
  logic                      hit;

  always_comb begin
    fwd       = rb_valid_i && (rb_reg_i == lk_reg_i);
    sel_valid = fwd ? 1'b1     : valid_a[lk_reg_i];
    sel_bound = fwd ? rb_bound : bound_a[lk_reg_i];
    sel_ptr   = fwd ? rb_ptr   : ptr_a[lk_reg_i];
  end

  wrt_range_check #(.OFF_W(OFF_W), .BOUND_W(BOUND_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .valid_i(sel_valid), .bound_i(sel_bound), .off_i(lk_off_i), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_valid_o <= 1'b0;
      direct_o    <= 1'b0;
      way_o       <= '0;
      set_o       <= '0;
    end else begin
      acc_valid_o <= lk_valid_i;
      direct_o    <= lk_valid_i && hit;
      way_o       <= (lk_valid_i && hit) ? sel_ptr[WAY_W-1:0] : '0;
      set_o       <= (lk_valid_i && hit) ? sel_ptr[PTR_W-1:WAY_W] : '0;
    end
  end

  assert_direct_has_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_o |-> acc_valid_o);

  assert_idle_no_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> (!acc_valid_o && !direct_o));

  assert_gated_ptr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !direct_o |-> (way_o == '0 && set_o == '0));

  assert_fwd_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && rb_valid_i && rb_reg_i == lk_reg_i && lk_off_i == rb_off_i) |=> direct_o);
endmodule

// File: tb/way_record_table_test.sv
`timescale 1ns/1ps
module way_record_table_test;
  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;

  logic              lk_v = 0, rb_v = 0, wr_v = 0, wr_a = 0;
  logic [3:0]        lk_r = 0, rb_r = 0, wr_r = 0;
  logic signed [11:0] lk_o = 0, rb_o = 0, wr_i = 0;
  logic [5:0]        rb_pos = 0, rb_set = 0;
  logic [1:0]        rb_way = 0;
  logic              acc, dir;
  logic [1:0]        way;
  logic [5:0]        set;

  way_record_table uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_v), .lk_reg_i(lk_r), .lk_off_i(lk_o),
    .rb_valid_i(rb_v), .rb_reg_i(rb_r), .rb_off_i(rb_o), .rb_pos_i(rb_pos),
    .rb_way_i(rb_way), .rb_set_i(rb_set),
    .wr_valid_i(wr_v), .wr_reg_i(wr_r), .wr_addi_i(wr_a), .wr_imm_i(wr_i),
    .acc_valid_o(acc), .direct_o(dir), .way_o(way), .set_o(set)
  );

  int checks = 0, failures = 0;
  int mv[16], mb[16], mw[16], ms[16];
  bit done = 0;

  task automatic step(input string tag);
    int v, b, w, s, o, nb;
    bit h;
    v = 0; b = 0; w = 0; s = 0; o = lk_o;
    if (rb_v && rb_r == lk_r) begin
      v = 1; b = int'(rb_o) - int'(rb_pos); w = rb_way; s = rb_set;
    end else begin
      v = mv[lk_r]; b = mb[lk_r]; w = mw[lk_r]; s = ms[lk_r];
    end
    h = lk_v && v && o >= b && o < b + 64;
    @(posedge clk); #1;
    checks++;
    if (acc !== lk_v || dir !== h || way !== (h ? w[1:0] : 2'd0) || set !== (h ? s[5:0] : 6'd0)) begin
      failures++;
      $display("FAIL %s acc=%0d/%0d direct=%0d/%0d way=%0d/%0d set=%0d/%0d",
               tag, acc, lk_v, dir, h, way, h ? w : 0, set, h ? s : 0);
    end
    if (rb_v) begin
      mv[rb_r] = 1; mb[rb_r] = int'(rb_o) - int'(rb_pos); mw[rb_r] = rb_way; ms[rb_r] = rb_set;
    end
    if (wr_v && !(rb_v && rb_r == wr_r)) begin
      if (wr_a) begin
        nb = mb[wr_r] - int'(wr_i);
        if (nb > 8191 || nb < -8192) mv[wr_r] = 0; else mb[wr_r] = nb;
      end else mv[wr_r] = 0;
    end
    lk_v = 0; rb_v = 0; wr_v = 0; wr_a = 0;
  endtask

  task automatic look(input int r, input int o, input string tag);
    lk_v = 1; lk_r = 4'(r); lk_o = 12'(o); step(tag);
  endtask

  task automatic rebuild(input int r, input int o, input int pos, input int w, input int s);
    rb_v = 1; rb_r = 4'(r); rb_o = 12'(o); rb_pos = 6'(pos); rb_way = 2'(w); rb_set = 6'(s);
  endtask

  task automatic rwrite(input int r, input bit addi, input int imm);
    wr_v = 1; wr_r = 4'(r); wr_a = addi; wr_i = 12'(imm);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mb[i] = 0; mw[i] = 0; ms[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (acc !== 0 || dir !== 0 || way !== 0 || set !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs acc=%0d dir=%0d way=%0d set=%0d expected 0", acc, dir, way, set);
    end
    rst_ni = 1;
    for (int r = 0; r < 16; r++) look(r, 0, "R1");

    // R3 R2 R10: rebuild each register, sweep offsets across both window edges
    for (int r = 0; r < 16; r++) begin
      rebuild(r, (r * 37) % 200 - 100, (r * 13) % 64, r % 4, r * 3); step("R3");
    end
    for (int r = 0; r < 16; r++)
      for (int d = -3; d < 67; d++) look(r, mb[r] + d, "R2");
    // worked example: offset 4 at position 12 -> window -8..55
    rebuild(2, 4, 12, 3, 9); step("R3");
    look(2, -9, "R3"); look(2, -8, "R3"); look(2, 55, "R3"); look(2, 56, "R3");
    rebuild(2, 64, 8, 1, 10); step("R3");
    look(2, 55, "R3"); look(2, 56, "R3"); look(2, 119, "R3"); look(2, 120, "R3");
    for (int r = 0; r < 16; r++) look(r, mb[r], "R10");

    // R8: back-to-back forwarding
    rebuild(5, 100, 20, 2, 33); look(5, 100, "R8");
    rebuild(5, -300, 0, 1, 7); look(5, 0, "R8");
    rebuild(6, 40, 1, 3, 44); look(5, -300, "R8_other_reg");

    // R5: add-immediate shifts the window
    rebuild(3, 0, 0, 2, 5); step("R5");
    rwrite(3, 1, 20); step("R5");
    for (int d = -3; d < 67; d++) look(3, -20 + d, "R5");
    rwrite(3, 1, -40); step("R5");
    for (int d = -3; d < 67; d++) look(3, 20 + d, "R5");

    // R4: plain write clears
    rwrite(3, 0, 0); step("R4");
    for (int d = 0; d < 64; d += 9) look(3, 20 + d, "R4");

    // R7: rebuild beats write in same cycle
    rebuild(4, 10, 10, 1, 17); rwrite(4, 0, 0); step("R7");
    look(4, 0, "R7"); look(4, 63, "R7");
    rebuild(4, 10, 0, 2, 18); rwrite(4, 1, 500); step("R7");
    look(4, 10, "R7"); look(4, 73, "R7");

    // R9: write in lookup cycle is not seen by that lookup
    rwrite(4, 0, 0); look(4, 10, "R9"); look(4, 10, "R9");
    rebuild(8, 0, 0, 3, 2); step("R9");
    rwrite(8, 1, 64); look(8, 0, "R9"); look(8, 0, "R9"); look(8, -64, "R9");

    // R6: bound overflow invalidates, no wrap
    rebuild(9, 0, 0, 1, 1); step("R6");
    for (int k = 0; k < 3; k++) begin rwrite(9, 1, -2048); step("R6"); end
    for (int k = 0; k < 3; k++) begin rwrite(9, 1, 2047); step("R6"); end
    look(9, 3, "R6_no_ovf");
    rebuild(10, 0, 0, 2, 2); step("R6");
    for (int k = 0; k < 4; k++) begin rwrite(10, 1, -2048); step("R6"); end
    for (int k = 0; k < 4; k++) begin rwrite(10, 1, 2047); step("R6"); end
    look(10, 4, "R6_ovf"); look(10, 4 + 63, "R6_ovf");
    rebuild(11, 0, 0, 3, 3); step("R6");
    for (int k = 0; k < 5; k++) begin rwrite(11, 1, 2047); step("R6"); end
    for (int k = 0; k < 5; k++) begin rwrite(11, 1, -2047); step("R6"); end
    look(11, 0, "R6_neg_ovf");

    // R11 and mixed traffic
    lf = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      int r, o;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      r = int'(lf % 16);
      o = mb[r] + int'((lf >> 4) % 80) - 8;
      if (o > 2047) o = 2047;
      if (o < -2048) o = -2048;
      if (((lf >> 12) % 4) == 0)
        rebuild(int'((lf >> 14) % 16), int'((lf >> 18) % 512) - 256, int'((lf >> 8) % 64),
                int'((lf >> 20) % 4), int'((lf >> 22) % 64));
      if (((lf >> 24) % 3) == 0)
        rwrite(int'((lf >> 26) % 16), lf[30],
               lf[31] ? (lf[29] ? 2047 : -2048) : int'((lf >> 5) % 256) - 128);
      lk_v = lf[3]; lk_r = 4'(r); lk_o = 12'(o);
      step("R11");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule